// File: doc/BRIEF.md
# Nibble-Register Cartridge Mapper Interface

This block is the host-facing controller of a cartridge. The host CPU sees it through an 8-bit bus that carries only 4-bit payloads. One strobe selects a register index. A second strobe writes a nibble into the selected register. The low four bits of a small register file hold the ROM bank number, a data byte split over two nibbles, and a packed address/command. A single write to the low address register executes the transaction that those nibbles describe. The transaction is one of these: a byte store into a 32-byte battery RAM, the setup for a RAM read, a minute or hour set, or an indexed write into a 16-entry page of clock digits.

Results come back through two read registers. One returns the low nibble of the result and the other returns the high nibble, with the upper half of the bus driven high. A fixed status register identifies the controller. The page of clock digits is brought out as a flat port, so that a separate time-keeping block can observe the digits and advance them. The command decode, the RAM and the read path are all inside this block.

Top module: `nibble_mapper`

## Requirements
- R1: After reset the selected index is 0, all eight writable registers are 0, the dirty flag is 0, every page digit is 0 and the read bus shows 0xF0.
- R2: A select strobe loads the selected index from bus bits 3:0. A data strobe stores bus bits 3:0 into the selected register when the index is 0 to 7 and does nothing for indices 8 to 15. The bank output is {register 1, register 0}.
- R3: Writes to registers other than index 7 never touch the RAM, the page or the dirty flag.
- R4: A data write to index 7 with command (register 6 >> 1) equal to 0 stores the byte {register 5, register 4} into RAM at the address {register 6 bit 0, written nibble} and sets the sticky dirty flag.
- R5: With command 1, read index 0xC returns {0xF, RAM byte bits 3:0} and read index 0xD returns {0xF, RAM byte bits 7:4}, using the address {register 6 bit 0, register 7}.
- R6: Command 2 executed at address 4 loads page digit 2 with the data byte's low nibble and page digit 3 with its high nibble. At address 5 it loads digits 4 and 5 in the same way.
- R7: Under command 2 the result byte is {digit 3, digit 2} at address 6, {digit 5, digit 4} at address 7, and the 5-bit address itself at any other address.
- R8: Command 4 executed at an even address writes page digit [data bits 3:0] with data bits 7:4. At an odd address it does nothing.
- R9: Under command 4, read index 0xC returns {0xF, page digit [register 4]}, and read index 0xD returns the default result 0xF0 as 0xFF.
- R10: Index 0xA reads 0xF1. Indices other than 0xA, 0xC and 0xD read 0xF0. Any command other than 1, 2 or 4 gives the result byte 0xF0.
- R11: Executing commands 3, 5, 6 or 7 changes neither the RAM, the page nor the dirty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Load the selected index from host_wdata[3:0] |
| host_wr | input | 1 | Write host_wdata[3:0] into the selected register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read value for the selected index |
| bank_num | output | 8 | ROM bank number {reg 1, reg 0} |
| ram_dirty | output | 1 | Sticky flag set by every RAM store |
| page_digits | output | 64 | Clock digit page, digit i at bits 4i+3:4i |

## Verification
Every strobe takes effect at the next rising edge: register, index, RAM, page and dirty updates are all due one cycle after the strobe. The read bus is a combinational function of that state, so a read result is due in the same cycle as the state it depends on. The bench drives strobes on the falling edge, and the strobe is registered at the rising edge that follows. Half a cycle after that edge, the bench compares the read bus, the bank, the dirty flag and the whole page against its own model. It makes this check after every operation. It also reads back the RAM by switching to command 1 and selecting the read indices.

// File: rtl/nm_pkg.sv
package nm_pkg;
   localparam int NIB = 4;
   // register indices
   localparam logic [3:0] IX_BANK_LO = 4'h0;
   localparam logic [3:0] IX_BANK_HI = 4'h1;
   localparam logic [3:0] IX_DAT_LO  = 4'h4;
   localparam logic [3:0] IX_DAT_HI  = 4'h5;
   localparam logic [3:0] IX_ADR_HI  = 4'h6;
   localparam logic [3:0] IX_ADR_LO  = 4'h7;
   localparam logic [3:0] IX_STATUS  = 4'hA;
   localparam logic [3:0] IX_RES_LO  = 4'hC;
   localparam logic [3:0] IX_RES_HI  = 4'hD;
   // command codes
   typedef enum logic [2:0] {
      CMD_RAM_WR = 3'd0,
      CMD_RAM_RD = 3'd1,
      CMD_TIME   = 3'd2,
      CMD_PAGE   = 3'd4
   } cmd_e;
   // addresses under the time command
   localparam logic [4:0] TA_SET_MIN = 5'd4;
   localparam logic [4:0] TA_SET_HR  = 5'd5;
   localparam logic [4:0] TA_GET_MIN = 5'd6;
   localparam logic [4:0] TA_GET_HR  = 5'd7;
   // digit positions in the page
   localparam int PG_MIN_ONES = 2;
   localparam int PG_HR_ONES  = 4;
   localparam logic [7:0] STATUS_VAL  = 8'hF1;
   localparam logic [7:0] DEFAULT_VAL = 8'hF0;
endpackage

// File: rtl/nm_regfile.sv
module nm_regfile #(
   parameter int NIB_W = 4,
   parameter int NREG  = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sel_we,
   input  logic                        data_we,
   input  logic [NIB_W-1:0]            wnib,
   output logic [NIB_W-1:0]            idx,
   output logic [NREG-1:0][NIB_W-1:0]  regs
);
   localparam int IDX_LIM = NREG;

   always_ff @(posedge clk) begin
      if (!rst_n) idx <= '0;
      else if (sel_we) idx <= wnib;
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) regs[g] <= '0;
         else if (data_we && (int'(idx) == g)) regs[g] <= wnib;
      end
   end

   p_store_nibble_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && int'(idx) < IDX_LIM) |=> (regs[$past(idx[2:0])] == $past(wnib)));
   p_high_index_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && int'(idx) >= IDX_LIM) |=> $stable(regs));
endmodule

// File: rtl/nm_ram.sv
module nm_ram #(
   parameter int DEPTH = 32,
   parameter int BYTE_W = 8,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [BYTE_W-1:0] rdata
);
   logic [DEPTH-1:0][BYTE_W-1:0] mem;

   if (CLEAR_ON_RESET) begin : g_clr
      always_ff @(posedge clk) begin
         if (!rst_n) mem <= '0;
         else if (we) mem[waddr] <= wdata;
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (we) mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

   p_ram_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/nm_digit_page.sv
module nm_digit_page #(
   parameter int NIB_W = 4,
   parameter int DEPTH = 16,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       one_we,
   input  logic [IW-1:0]              one_idx,
   input  logic [NIB_W-1:0]           one_val,
   input  logic                       pair_we,
   input  logic [IW-1:0]              pair_base,
   input  logic [2*NIB_W-1:0]         pair_val,
   output logic [DEPTH-1:0][NIB_W-1:0] digits
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_dig
      always_ff @(posedge clk) begin
         if (!rst_n) digits[g] <= '0;
         else if (pair_we && int'(pair_base) == g) digits[g] <= pair_val[NIB_W-1:0];
         else if (pair_we && int'(pair_base) + 1 == g) digits[g] <= pair_val[2*NIB_W-1:NIB_W];
         else if (one_we && int'(one_idx) == g) digits[g] <= one_val;
      end
   end

   p_one_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (one_we && !pair_we) |=> (digits[$past(one_idx)] == $past(one_val)));
   p_pair_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pair_we |=> (digits[$past(pair_base)] == $past(pair_val[NIB_W-1:0])));
endmodule

// File: rtl/nm_readout.sv
module nm_readout
   import nm_pkg::*;
#(
   parameter int NIB_W = 4,
   parameter int PAGE_DEPTH = 16,
   localparam int BW = 2*NIB_W
) (
   input  logic [NIB_W-1:0]                idx,
   input  logic [2:0]                      cmd,
   input  logic [NIB_W:0]                  addr,
   input  logic [NIB_W-1:0]                sel_digit,
   input  logic [BW-1:0]                   ram_byte,
   input  logic [PAGE_DEPTH-1:0][NIB_W-1:0] digits,
   output logic [BW-1:0]                   bus
);
   logic [BW-1:0] result;
   logic          is_hi;

   assign is_hi = (idx == IX_RES_HI);

   always_comb begin
      result = DEFAULT_VAL;
      unique case (cmd)
         CMD_RAM_RD: result = ram_byte;
         CMD_TIME: begin
            if (addr == TA_GET_MIN)
               result = {digits[PG_MIN_ONES+1], digits[PG_MIN_ONES]};
            else if (addr == TA_GET_HR)
               result = {digits[PG_HR_ONES+1], digits[PG_HR_ONES]};
            else
               result = BW'(addr);
         end
         CMD_PAGE: begin
            if (!is_hi) result = {{NIB_W{1'b0}}, digits[sel_digit]};
         end
         default: result = DEFAULT_VAL;
      endcase
   end

   always_comb begin
      if (idx == IX_STATUS)      bus = STATUS_VAL;
      else if (idx == IX_RES_LO) bus = {{NIB_W{1'b1}}, result[NIB_W-1:0]};
      else if (idx == IX_RES_HI) bus = {{NIB_W{1'b1}}, result[BW-1:NIB_W]};
      else                       bus = DEFAULT_VAL;
   end

   always_comb begin
      if (idx == IX_RES_LO || idx == IX_RES_HI)
         p_upper_ones_r5: assert (bus[BW-1:NIB_W] == {NIB_W{1'b1}});
   end
endmodule

// File: rtl/nibble_mapper.sv
module nibble_mapper
   import nm_pkg::*;
#(
   parameter int NIB_W = 4,
   parameter int RAM_DEPTH = 32,
   parameter int PAGE_DEPTH = 16,
   parameter bit RAM_CLEAR_ON_RESET = 1'b1,
   localparam int BW = 2*NIB_W,
   localparam int AW = NIB_W + 1,
   localparam int NREG = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_sel,
   input  logic                       host_wr,
   input  logic [7:0]                 host_wdata,
   output logic [7:0]                 host_rdata,
   output logic [7:0]                 bank_num,
   output logic                       ram_dirty,
   output logic [PAGE_DEPTH*NIB_W-1:0] page_digits
);
   initial begin
      p_params_ok: assert (NIB_W == 4 && RAM_DEPTH == (1 << AW) && PAGE_DEPTH == (1 << NIB_W))
         else $error("nibble_mapper: unsupported parameter set");
   end

   logic [NIB_W-1:0]               idx;
   logic [NREG-1:0][NIB_W-1:0]     regs;
   logic [PAGE_DEPTH-1:0][NIB_W-1:0] digits;
   logic [BW-1:0]                  ram_byte;

   nm_regfile #(.NIB_W(NIB_W), .NREG(NREG)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel_we(host_sel), .data_we(host_wr),
      .wnib(host_wdata[NIB_W-1:0]), .idx(idx), .regs(regs));

   // transaction formed from the stored nibbles plus the nibble being written
   logic          exec;
   logic [2:0]    exec_cmd;
   logic [AW-1:0] exec_addr;
   logic [BW-1:0] exec_byte;
   assign exec      = host_wr && (idx == IX_ADR_LO);
   assign exec_cmd  = regs[IX_ADR_HI][NIB_W-1:1];
   assign exec_addr = {regs[IX_ADR_HI][0], host_wdata[NIB_W-1:0]};
   assign exec_byte = {regs[IX_DAT_HI], regs[IX_DAT_LO]};

   logic ram_we, one_we, pair_we;
   logic [NIB_W-1:0] pair_base;
   assign ram_we  = exec && (exec_cmd == CMD_RAM_WR);
   assign one_we  = exec && (exec_cmd == CMD_PAGE) && !exec_addr[0];
   assign pair_we = exec && (exec_cmd == CMD_TIME) &&
                    (exec_addr == TA_SET_MIN || exec_addr == TA_SET_HR);
   assign pair_base = (exec_addr == TA_SET_MIN) ? NIB_W'(PG_MIN_ONES) : NIB_W'(PG_HR_ONES);

   nm_ram #(.DEPTH(RAM_DEPTH), .BYTE_W(BW), .CLEAR_ON_RESET(RAM_CLEAR_ON_RESET)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(exec_addr), .wdata(exec_byte),
      .raddr({regs[IX_ADR_HI][0], regs[IX_ADR_LO]}), .rdata(ram_byte));

   nm_digit_page #(.NIB_W(NIB_W), .DEPTH(PAGE_DEPTH)) u_page (
      .clk(clk), .rst_n(rst_n),
      .one_we(one_we), .one_idx(exec_byte[NIB_W-1:0]), .one_val(exec_byte[BW-1:NIB_W]),
      .pair_we(pair_we), .pair_base(pair_base), .pair_val(exec_byte),
      .digits(digits));

   always_ff @(posedge clk) begin
      if (!rst_n) ram_dirty <= 1'b0;
      else if (ram_we) ram_dirty <= 1'b1;
   end

   nm_readout #(.NIB_W(NIB_W), .PAGE_DEPTH(PAGE_DEPTH)) u_rd (
      .idx(idx), .cmd(regs[IX_ADR_HI][NIB_W-1:1]),
      .addr({regs[IX_ADR_HI][0], regs[IX_ADR_LO]}),
      .sel_digit(regs[IX_DAT_LO]), .ram_byte(ram_byte), .digits(digits),
      .bus(host_rdata));

   assign bank_num    = {regs[IX_BANK_HI], regs[IX_BANK_LO]};
   assign page_digits = digits;

   p_dirty_on_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && idx == IX_ADR_LO && regs[IX_ADR_HI][NIB_W-1:1] == 3'd0) |=> ram_dirty);
   p_no_exec_elsewhere_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(host_wr && idx == IX_ADR_LO)) |=> ($stable(page_digits) && $stable(ram_dirty)));
   p_unknown_cmd_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && idx == IX_ADR_LO && regs[IX_ADR_HI][NIB_W-1:1] inside {3'd3, 3'd5, 3'd6, 3'd7})
      |=> ($stable(page_digits) && $stable(ram_dirty)));
   p_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == 4'hA) |-> (host_rdata == 8'hF1));
endmodule

// File: tb/sim_nibble_mapper.sv
`timescale 1ns/1ps
module sim_nibble_mapper;
   logic clk = 1'b0, rst_n = 1'b0, host_sel = 1'b0, host_wr = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata, bank_num;
   logic ram_dirty;
   logic [63:0] page_digits;

   always #2.5 clk = ~clk;

   nibble_mapper u0 (.clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .bank_num(bank_num),
      .ram_dirty(ram_dirty), .page_digits(page_digits));

   int n_chk = 0, n_fail = 0;
   logic [3:0] m_idx;
   logic [3:0] m_reg [8];
   logic [7:0] m_ram [32];
   logic [3:0] m_pg [16];
   logic m_dirty;
   bit done = 0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] m_cmd(); return m_reg[6][3:1]; endfunction
   function automatic logic [4:0] m_addr(); return {m_reg[6][0], m_reg[7]}; endfunction

   function automatic logic [7:0] m_result(input bit hi);
      logic [7:0] r = 8'hF0;
      case (m_cmd())
         3'd1: r = m_ram[m_addr()];
         3'd2: if (m_addr() == 5'd6) r = {m_pg[3], m_pg[2]};
               else if (m_addr() == 5'd7) r = {m_pg[5], m_pg[4]};
               else r = {3'b000, m_addr()};
         3'd4: if (!hi) r = {4'h0, m_pg[m_reg[4]]};
         default: r = 8'hF0;
      endcase
      return r;
   endfunction

   function automatic logic [7:0] m_bus();
      if (m_idx == 4'hA) return 8'hF1;
      if (m_idx == 4'hC) return {4'hF, m_result(0)[3:0]};
      if (m_idx == 4'hD) return {4'hF, m_result(1)[7:4]};
      return 8'hF0;
   endfunction

   function automatic string bus_tag();
      if (m_idx == 4'hC || m_idx == 4'hD)
         case (m_cmd()) 3'd1: return "R5"; 3'd2: return "R7"; 3'd4: return "R9"; default: return "R10"; endcase
      return "R10";
   endfunction

   function automatic logic [63:0] m_page();
      logic [63:0] p;
      for (int i = 0; i < 16; i++) p[4*i +: 4] = m_pg[i];
      return p;
   endfunction

   task automatic check_all(input string tag);
      check({tag, "/", bus_tag(), " bus"}, 64'(host_rdata), 64'(m_bus()));
      check({tag, "/R2 bank"}, 64'(bank_num), 64'({m_reg[1], m_reg[0]}));
      check({tag, "/R4 dirty"}, 64'(ram_dirty), 64'(m_dirty));
      check({tag, " page"}, page_digits, m_page());
   endtask

   task automatic sel(input logic [3:0] v);
      @(negedge clk); host_sel = 1'b1; host_wdata = {$urandom_range(15,0), v};
      @(negedge clk); host_sel = 1'b0;
      m_idx = v;
   endtask

   task automatic wr(input logic [3:0] v);
      logic [2:0] c;
      logic [4:0] a;
      logic [7:0] b;
      @(negedge clk); host_wr = 1'b1; host_wdata = {$urandom_range(15,0), v};
      @(negedge clk); host_wr = 1'b0;
      if (m_idx == 4'd7) begin
         c = m_reg[6][3:1]; a = {m_reg[6][0], v}; b = {m_reg[5], m_reg[4]};
         case (c)
            3'd0: begin m_ram[a] = b; m_dirty = 1'b1; end
            3'd2: if (a == 5'd4) begin m_pg[2] = b[3:0]; m_pg[3] = b[7:4]; end
                  else if (a == 5'd5) begin m_pg[4] = b[3:0]; m_pg[5] = b[7:4]; end
            3'd4: if (!a[0]) m_pg[b[3:0]] = b[7:4];
            default: ;
         endcase
      end
      if (m_idx < 4'd8) m_reg[m_idx[2:0]] = v;
   endtask

   task automatic put(input logic [3:0] i, input logic [3:0] v);
      sel(i); wr(v);
   endtask

   // full transaction: data byte, address-high, then address-low executes
   task automatic xact(input logic [3:0] ah, input logic [3:0] al, input logic [7:0] d);
      put(4'd4, d[3:0]); put(4'd5, d[7:4]); put(4'd6, ah); put(4'd7, al);
   endtask

   initial begin
      #(5.0 * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd7715));
      m_idx = 0; m_dirty = 0;
      for (int i = 0; i < 8; i++) m_reg[i] = 0;
      for (int i = 0; i < 32; i++) m_ram[i] = 0;
      for (int i = 0; i < 16; i++) m_pg[i] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 reset bus", 64'(host_rdata), 64'h00F0);
      check("R1 reset bank", 64'(bank_num), 64'h0);
      check("R1 reset dirty", 64'(ram_dirty), 64'h0);
      check("R1 reset page", page_digits, 64'h0);

      // R10 status and plain index
      sel(4'hA); check("R10 status", 64'(host_rdata), 64'h00F1);
      sel(4'h3); check("R10 non-read index", 64'(host_rdata), 64'h00F0);
      // R2 bank, high index ignored
      put(4'd0, 4'h9); put(4'd1, 4'h3);
      check("R2 bank", 64'(bank_num), 64'h39);
      put(4'hB, 4'h5); check_all("R2 high index");
      // R3 data regs do not execute
      put(4'd4, 4'h2); put(4'd5, 4'h7); put(4'd6, 4'h0);
      check("R3 dirty unchanged", 64'(ram_dirty), 64'h0);
      // R4 store and R5 read-back at top address
      xact(4'h1, 4'hF, 8'hA5);
      check("R4 dirty set", 64'(ram_dirty), 64'h1);
      put(4'd6, 4'h3); put(4'd7, 4'hF);
      sel(4'hC); check("R5 read low", 64'(host_rdata), 64'h00F5);
      sel(4'hD); check("R5 read high", 64'(host_rdata), 64'h00FA);
      // R6 minute/hour set, R7 packed reads
      xact(4'h4, 4'h4, 8'h59);
      xact(4'h4, 4'h5, 8'h23);
      check("R6 page", page_digits, m_page());
      put(4'd7, 4'h6); sel(4'hC); check("R7 minute low", 64'(host_rdata), 64'h00F9);
      sel(4'hD); check("R7 minute high", 64'(host_rdata), 64'h00F5);
      put(4'd7, 4'h7); sel(4'hD); check("R7 hour high", 64'(host_rdata), 64'h00F2);
      put(4'd7, 4'h9); sel(4'hC); check("R7 echo address", 64'(host_rdata), 64'h00F9);
      // R8 indexed digit write, odd address ignored
      xact(4'h8, 4'h2, 8'h7C);
      xact(4'h8, 4'h3, 8'h4E);
      check("R8 page", page_digits, m_page());
      put(4'd4, 4'hC); sel(4'hC); check("R9 read low", 64'(host_rdata), 64'h00F7);
      sel(4'hD); check("R9 read high default", 64'(host_rdata), 64'h00FF);
      // R11 unknown commands inert
      for (int c = 3; c < 8; c += 2) begin
         xact(4'(c << 1), 4'h2, 8'h3A); check_all("R11 unknown cmd");
      end
      xact(4'hC, 4'h0, 8'h11); check_all("R11 unknown cmd 6");

      // constrained random traffic
      for (int k = 0; k < 3000; k++) begin
         int r = $urandom_range(9, 0);
         if (r < 4) begin
            logic [3:0] pick [7] = '{4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hC, 4'hD};
            if (r == 0) sel(4'($urandom_range(15, 0)));
            else sel(pick[$urandom_range(6, 0)]);
         end else if (r < 9) begin
            logic [3:0] v = 4'($urandom_range(15, 0));
            if (m_idx == 4'd6) v = {3'($urandom_range(4, 0)), v[0]};
            wr(v);
         end else begin
            put(4'd6, 4'h2); put(4'd7, 4'($urandom_range(15, 0)));
            sel(4'hC);
         end
         check_all("rand");
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule